// File: doc/BRIEF.md
# Glitch-free clock stop controller

This block gates two groups of internal clocks in answer to two asynchronous, active-low stop requests. One group is a pair of processor clocks. The other is a bus clock group, made up of several bus clock copies and one early copy that leads them. The internal clocks reach the block as toggling levels sampled by a faster master clock. All gating happens in that master domain, so every output is a flop or the AND of two flops.

Each stop request first passes through a multi-flop synchronizer. The resulting decision is applied only at a falling edge of the internal clock it controls. A clock therefore always stops in the low state, and the first pulse after a restart is a full high phase. Each group has a minimum run length that is counted in its own clock pulses: 100 for the processor pair and 10 for the bus group. A stop that arrives before that count is reached is held off until the count completes, and a flag stays high while the stop is held off. A free-running bus clock is never gated. A static select can exempt processor clock 0 from stopping.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst_n` is low every output is 0. After reset the gated outputs stay low through the first high phase of their internal clock. Each gated group starts running at the first falling edge of its internal clock.
- R2: While `cpu_stop_n` is low, `cpu_clk1` (and `cpu_clk0` when `sel_cpu0_free_n` is 1) is low no later than SYNC_STAGES plus one internal processor period plus 2 master cycles after the request, which is below 4 processor clocks. It stays low until the request is released.
- R3: Every high pulse on a gated output begins at a rise of its internal clock and lasts the full internal high phase. A group is only ever stopped or started while its clock is low.
- R4: After `cpu_stop_n` returns high, the first `cpu_clk1` high pulse appears within SYNC_STAGES plus 1.5 processor periods plus 2 master cycles.
- R5: After every processor restart, including the first start after reset, at least CPU_MIN_ON pulses pass before a stop takes effect. A stop requested earlier takes effect right after pulse number CPU_MIN_ON.
- R6: `cpu_hold_viol` is 1 while a processor stop request is being held off by R5, and 0 once the stop has taken effect or the request has gone. While it is 1 the processor clocks keep running.
- R7: Once synchronized, a bus stop request gates the bus group at the next falling edge of `pci_clk_in`. On release, the group restarts at the next falling edge, so the first rising edge after that falling edge is passed.
- R8: After every bus restart, at least PCI_MIN_ON bus pulses pass before a bus stop takes effect. A stop requested earlier takes effect right after pulse number PCI_MIN_ON. `pci_hold_viol` is 1 while such a request is held off and 0 otherwise.
- R9: `pci_clk_free` is never stopped. `pci_clk_early` is gated together with the bus group. Every bit of `pci_clk` equals `pci_clk_early` delayed by exactly one master cycle.
- R10: A processor stop leaves the bus outputs and `pci_clk_free` running undisturbed. A bus stop leaves the processor outputs running undisturbed.
- R11: With `sel_cpu0_free_n` at 0, `cpu_clk0` follows the processor clock and ignores `cpu_stop_n`. With it at 1, `cpu_clk0` equals `cpu_clk1`. The select may only change while the processor clocks are running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, faster than both internal clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk_in | input | 1 | Internal processor clock as a level sampled by `clk` |
| pci_clk_in | input | 1 | Internal bus clock as a level sampled by `clk` |
| cpu_stop_n | input | 1 | Asynchronous active-low processor stop request |
| pci_stop_n | input | 1 | Asynchronous active-low bus stop request |
| sel_cpu0_free_n | input | 1 | Static select; 0 makes `cpu_clk0` free-running |
| cpu_clk0 | output | 1 | Processor clock 0, gated unless exempted |
| cpu_clk1 | output | 1 | Processor clock 1, gated |
| pci_clk | output | PCI_WIDTH | Gated bus clock copies |
| pci_clk_early | output | 1 | Gated bus clock, one master cycle ahead of `pci_clk` |
| pci_clk_free | output | 1 | Ungated bus clock, aligned with `pci_clk` |
| cpu_hold_viol | output | 1 | Processor stop is being held off by the minimum run rule |
| pci_hold_viol | output | 1 | Bus stop is being held off by the minimum run rule |

## Verification
The bench measures every high pulse on every output. A design that gates at the wrong phase shows up as a pulse narrower than the internal high phase. It also counts pulses between stops. A design that ignores or miscounts the minimum run either stops after fewer than 100 or 10 pulses, or does not stop after exactly that many when the stop arrives early. Directed cases release a stop and re-request it at once. They also bring a group up from reset during the internal high phase, stop one group while watching the other and the free clock, and stop the processor pair with clock 0 exempted, so that a synchronizer of the wrong depth, cross-coupled domains or a misrouted select each changes a measured count. Random stretches of both stops, some shorter than the minimum run, check that no runt pulse and no early stop appears under arbitrary overlap.

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int CPU_MIN_ON  = 100,
  parameter int PCI_MIN_ON  = 10,
  parameter int PCI_WIDTH   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_clk_in,
  input  logic                 pci_clk_in,
  input  logic                 cpu_stop_n,
  input  logic                 pci_stop_n,
  input  logic                 sel_cpu0_free_n,
  output logic                 cpu_clk0,
  output logic                 cpu_clk1,
  output logic [PCI_WIDTH-1:0] pci_clk,
  output logic                 pci_clk_early,
  output logic                 pci_clk_free,
  output logic                 cpu_hold_viol,
  output logic                 pci_hold_viol
);
  localparam int MAX_MIN = (CPU_MIN_ON > PCI_MIN_ON) ? CPU_MIN_ON : PCI_MIN_ON;
  localparam int CW      = $clog2(MAX_MIN + 1);

  logic [1:0] ref_clk, stop_n, clk_q, en, viol;
  assign ref_clk = {pci_clk_in, cpu_clk_in};
  assign stop_n  = {pci_stop_n, cpu_stop_n};

  // index 0: processor pair, index 1: bus group
  for (genvar g = 0; g < 2; g++) begin : g_dom
    localparam int            MIN_ON = (g == 0) ? CPU_MIN_ON : PCI_MIN_ON;
    localparam logic [CW-1:0] LAST   = CW'(MIN_ON - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt;
    logic                   q, on, hold, req, fall;

    assign req  = ~sync_q[SYNC_STAGES-1];
    assign fall = q & ~ref_clk[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        q      <= 1'b0;
        on     <= 1'b0;
        hold   <= 1'b0;
        cnt    <= '0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], stop_n[g]};
        q      <= ref_clk[g];
        if (fall) begin
          if (on) begin
            if (req) begin
              if (cnt == LAST) begin
                on   <= 1'b0;
                hold <= 1'b0;
              end else begin
                hold <= 1'b1;
              end
            end else begin
              hold <= 1'b0;
            end
            if (cnt != LAST) cnt <= cnt + CW'(1);
          end else if (!req) begin
            on  <= 1'b1;
            cnt <= '0;
          end
        end
      end
    end

    assign clk_q[g] = q;
    assign en[g]    = on;
    assign viol[g]  = hold;
  end

  logic pci_q2, pci_en_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_q2   <= 1'b0;
      pci_en_d <= 1'b0;
    end else begin
      pci_q2   <= clk_q[1];
      pci_en_d <= en[1];
    end
  end

  assign cpu_clk1      = clk_q[0] & en[0];
  assign cpu_clk0      = clk_q[0] & (en[0] | ~sel_cpu0_free_n);
  assign pci_clk_early = clk_q[1] & en[1];
  assign pci_clk       = {PCI_WIDTH{pci_q2 & pci_en_d}};
  assign pci_clk_free  = pci_q2;
  assign cpu_hold_viol = viol[0];
  assign pci_hold_viol = viol[1];
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_clk_in,
  input logic pci_clk_in,
  input logic sel_cpu0_free_n,
  input logic cpu_clk0,
  input logic cpu_clk1,
  input logic pci_clk0,
  input logic pci_clk_early,
  input logic pci_clk_free,
  input logic cpu_hold_viol,
  input logic pci_hold_viol
);
  p_cpu_rise_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk1) |-> ($past(cpu_clk_in) && !$past(cpu_clk_in, 2)));
  p_cpu_fall_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk1) |-> (!$past(cpu_clk_in) && $past(cpu_clk_in, 2)));
  p_pci_rise_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_clk0) |-> ($past(pci_clk_in, 2) && !$past(pci_clk_in, 3)));
  p_pci_fall_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pci_clk0) |-> (!$past(pci_clk_in, 2) && $past(pci_clk_in, 3)));
  p_early_lead_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pci_clk0 == $past(pci_clk_early));
  p_free_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_clk_free) |-> ($past(pci_clk_in, 2) && !$past(pci_clk_in, 3)));
  p_gated_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pci_clk0 |-> pci_clk_free);
  p_cpu0_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_cpu0_free_n && !$past(sel_cpu0_free_n)) |-> (cpu_clk0 == $past(cpu_clk_in)));
  p_cpu_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cpu0_free_n |-> (cpu_clk0 == cpu_clk1));
  p_cpu_hold_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hold_viol |-> (cpu_clk1 == $past(cpu_clk_in)));
  p_pci_hold_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pci_hold_viol |-> (pci_clk_early == $past(pci_clk_in)));
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_clk_in     (cpu_clk_in),
  .pci_clk_in     (pci_clk_in),
  .sel_cpu0_free_n(sel_cpu0_free_n),
  .cpu_clk0       (cpu_clk0),
  .cpu_clk1       (cpu_clk1),
  .pci_clk0       (pci_clk[0]),
  .pci_clk_early  (pci_clk_early),
  .pci_clk_free   (pci_clk_free),
  .cpu_hold_viol  (cpu_hold_viol),
  .pci_hold_viol  (pci_hold_viol)
);

// File: tb/clk_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb_top;
  localparam int CPU_HALF = 3;
  localparam int PCI_HALF = 5;
  localparam int SYNC     = 2;
  localparam int CPU_MIN  = 100;
  localparam int PCI_MIN  = 10;
  localparam int PW       = 5;
  localparam int HALFS [5] = '{CPU_HALF, CPU_HALF, PCI_HALF, PCI_HALF, PCI_HALF};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_clk_in = 1'b0, pci_clk_in = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, sel_cpu0_free_n = 1'b1;
  logic cpu_clk0, cpu_clk1, pci_clk_early, pci_clk_free, cpu_hold_viol, pci_hold_viol;
  logic [PW-1:0] pci_clk;

  clk_stop_ctrl #(.SYNC_STAGES(SYNC), .CPU_MIN_ON(CPU_MIN), .PCI_MIN_ON(PCI_MIN),
                  .PCI_WIDTH(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_clk_in(cpu_clk_in), .pci_clk_in(pci_clk_in),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .sel_cpu0_free_n(sel_cpu0_free_n),
    .cpu_clk0(cpu_clk0), .cpu_clk1(cpu_clk1), .pci_clk(pci_clk),
    .pci_clk_early(pci_clk_early), .pci_clk_free(pci_clk_free),
    .cpu_hold_viol(cpu_hold_viol), .pci_hold_viol(pci_hold_viol));

  initial forever #4 clk = ~clk;

  int nchk = 0, nfail = 0, wd = 0;
  bit done = 0, clk_run = 0, mon_on = 0;
  int cc = 0, pc = 0;
  int hi [5], lo [5], run [5], rises [5];
  logic prev [5];
  logic s [5];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_range(input int v, input int lo_v, input int hi_v, input string tag);
    chk(v >= lo_v && v <= hi_v, tag, v, (lo_v + hi_v) / 2);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_counts();
    for (int k = 0; k < 5; k++) rises[k] = 0;
  endtask

  always @(negedge clk) begin
    if (clk_run) begin
      if (cc == CPU_HALF - 1) begin cc <= 0; cpu_clk_in <= ~cpu_clk_in; end
      else cc <= cc + 1;
      if (pc == PCI_HALF - 1) begin pc <= 0; pci_clk_in <= ~pci_clk_in; end
      else pc <= pc + 1;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      s[0] = cpu_clk1; s[1] = cpu_clk0; s[2] = pci_clk[0]; s[3] = pci_clk_early; s[4] = pci_clk_free;
      chk(s[2] == prev[3], "R9 bus group lags early clock by one cycle", int'(s[2]), int'(prev[3]));
      for (int k = 0; k < 5; k++) begin
        if (s[k]) begin
          if (!prev[k]) rises[k]++;
          hi[k]++;
          lo[k] = 0;
        end else begin
          if (prev[k]) begin
            chk(hi[k] == HALFS[k], "R3 full high pulse width", hi[k], HALFS[k]);
            run[k]++;
            hi[k] = 0;
          end
          lo[k]++;
          if (lo[k] == HALFS[k] + 1 && run[k] > 0) begin
            if (k == 0) chk(run[k] >= CPU_MIN, "R5 CPU pulses between stops", run[k], CPU_MIN);
            else if (k == 2 || k == 3) chk(run[k] >= PCI_MIN, "R8 bus pulses between stops", run[k], PCI_MIN);
            else if (k == 1 && !sel_cpu0_free_n) chk(0, "R11 free cpu_clk0 gap", lo[k], HALFS[k]);
            else if (k == 4) chk(0, "R9 free bus clock gap", lo[k], HALFS[k]);
            run[k] = 0;
          end
        end
        prev[k] = s[k];
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      nchk++; nfail++;
      $display("FAIL watchdog (all requirements): actual %0d expected below %0d", wd, 150000);
      summary();
    end
  end

  initial begin
    int waited;
    void'($urandom(32'd4711));
    for (int k = 0; k < 5; k++) begin hi[k] = 0; lo[k] = 0; run[k] = 0; rises[k] = 0; prev[k] = 0; end

    cyc(5);
    chk({cpu_clk0, cpu_clk1, pci_clk, pci_clk_early, pci_clk_free, cpu_hold_viol, pci_hold_viol} == '0,
        "R1 outputs low in reset",
        int'({cpu_clk0, cpu_clk1, pci_clk, pci_clk_early, pci_clk_free}), 0);
    rst_n = 1'b1;
    mon_on = 1;
    cyc(2);
    clk_run = 1;
    waited = 0;
    while (!cpu_clk_in && waited < 20) begin cyc(1); waited++; end
    cyc(2);
    chk(!cpu_clk1 && !pci_clk_early, "R1 first internal high phase not passed", int'(cpu_clk1), 0);
    cyc(40);
    chk(rises[0] > 0, "R1 processor group starts after reset", rises[0], 1);

    // R2 / R10: processor stop, bus untouched
    cyc(700);
    cpu_stop_n = 1'b0;
    cyc(SYNC + 2 * CPU_HALF + 2);
    chk(!cpu_clk1, "R2 cpu_clk1 low after off latency", int'(cpu_clk1), 0);
    clear_counts();
    cyc(240);
    chk(rises[0] == 0, "R2 cpu_clk1 held stopped", rises[0], 0);
    chk(rises[1] == 0, "R11 cpu_clk0 follows cpu_clk1 when select is high", rises[1], 0);
    chk_range(rises[2], 23, 25, "R10 bus clocks run during processor stop");
    chk_range(rises[4], 23, 25, "R10 free bus clock runs during processor stop");

    // R4 / R5 / R6: release, re-request at once
    clear_counts();
    cpu_stop_n = 1'b1;
    waited = 0;
    while (rises[0] == 0 && waited < 60) begin cyc(1); waited++; end
    chk(waited <= SYNC + 3 * CPU_HALF + 2, "R4 processor on latency", waited, SYNC + 3 * CPU_HALF + 2);
    cpu_stop_n = 1'b0;
    cyc(300);
    chk(cpu_hold_viol, "R6 hold flag during minimum run", int'(cpu_hold_viol), 1);
    cyc(500);
    chk(rises[0] == CPU_MIN, "R5 stop lands right after minimum pulses", rises[0], CPU_MIN);
    chk(!cpu_hold_viol, "R6 hold flag clear after stop", int'(cpu_hold_viol), 0);
    chk(!cpu_clk1, "R5 processor stopped low", int'(cpu_clk1), 0);

    // R11: free-running clock 0
    cpu_stop_n = 1'b1;
    cyc(700);
    sel_cpu0_free_n = 1'b0;
    cyc(20);
    cpu_stop_n = 1'b0;
    cyc(SYNC + 2 * CPU_HALF + 2);
    clear_counts();
    cyc(240);
    chk_range(rises[1], 39, 41, "R11 cpu_clk0 ignores stop when exempt");
    chk(rises[0] == 0, "R2 cpu_clk1 stopped while clock 0 exempt", rises[0], 0);
    cpu_stop_n = 1'b1;
    cyc(700);
    sel_cpu0_free_n = 1'b1;
    cyc(20);

    // R7 / R9 / R10: bus stop
    pci_stop_n = 1'b0;
    cyc(SYNC + 2 * PCI_HALF + 2);
    clear_counts();
    cyc(200);
    chk(rises[2] == 0, "R7 bus group stopped", rises[2], 0);
    chk(rises[3] == 0, "R9 early clock stopped with group", rises[3], 0);
    chk_range(rises[4], 19, 21, "R9 free bus clock not stopped");
    chk_range(rises[0], 32, 34, "R10 processor clocks run during bus stop");

    // R7 / R8: bus release and early re-request
    clear_counts();
    pci_stop_n = 1'b1;
    waited = 0;
    while (rises[2] == 0 && waited < 60) begin cyc(1); waited++; end
    chk(waited <= SYNC + 3 * PCI_HALF + 3, "R7 bus on latency", waited, SYNC + 3 * PCI_HALF + 3);
    pci_stop_n = 1'b0;
    cyc(50);
    chk(pci_hold_viol, "R8 bus hold flag during minimum run", int'(pci_hold_viol), 1);
    cyc(150);
    chk(rises[2] == PCI_MIN, "R8 bus stop lands right after minimum pulses", rises[2], PCI_MIN);
    chk(rises[3] == PCI_MIN, "R9 early clock pulse count matches group", rises[3], PCI_MIN);
    chk(!pci_hold_viol, "R8 bus hold flag clear after stop", int'(pci_hold_viol), 0);

    // random overlap of both stops
    pci_stop_n = 1'b1;
    cyc(200);
    for (int i = 0; i < 40; i++) begin
      if ($urandom % 2 == 0) cpu_stop_n = ~cpu_stop_n;
      else pci_stop_n = ~pci_stop_n;
      cyc(20 + int'($urandom % 600));
    end
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    cyc(800);
    clear_counts();
    cyc(120);
    chk_range(rises[0], 19, 21, "R4 processor running after random phase");
    chk_range(rises[2], 11, 13, "R7 bus group running after random phase");
    summary();
  end
endmodule